// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial characters that carry one extra flag bit between the data byte and the stop bit. The flag marks a character as a station address (flag = 1) or as payload (flag = 0). That lets several receivers share one line while only the addressed station handles the payload.

Software can arm a skip mode through a one-bit write port. While skip mode is armed, payload characters pass through the receiver and leave no trace. The receive register, the full flag and the interrupt request all stay as they were. The first address character is delivered normally and disarms skip mode. Software then compares the address with its own station number. It either takes the payload that follows, or re-arms skip mode to ignore the rest of the message.

The line is oversampled by a factor set by a parameter. Each oversampling step is gated by an external sample-enable pulse, so the baud divider sits outside the block.

Top module: `mp_uart_rx`

## Requirements
- R1: A character is a 0 start bit, 8 data bits sent least significant bit first, the flag bit, and a 1 stop bit. An accepted character places its byte on `rx_data_o` and sets `rx_full_o`.
- R2: `flag_o` holds the flag bit of the most recently loaded character.
- R3: While skip mode is armed, a character whose flag bit is 0 leaves `rx_data_o`, `rx_full_o` and `irq_o` unchanged.
- R4: While skip mode is armed, a character whose flag bit is 1 is loaded and raises `rx_full_o` and the interrupt. It also clears skip mode, and `skip_o` reads 0 afterwards.
- R5: With skip mode disarmed, every character is accepted whatever its flag bit.
- R6: A one-cycle `rd_i` pulse clears `rx_full_o`, `ovr_o` and `ferr_o` on the next clock edge.
- R7: A cycle with `skip_wr_i` high loads `skip_wdata_i` into skip mode, seen on `skip_o` one cycle later. The write wins over the clear by an address character in the same cycle.
- R8: A low pulse on the line that is gone by the middle of the start bit does not start a character.
- R9: A stop bit sampled as 0 sets `ferr_o` for the accepted character. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R10: A character accepted while `rx_full_o` is still set raises `ovr_o` and leaves `rx_data_o` and `flag_o` unchanged.
- R11: `irq_o` is registered. It equals `rx_full_o` AND `irq_en_i`, with `irq_en_i` taken from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Serial line, idles at 1 |
| sample_en_i | input | 1 | Oversampling step enable |
| skip_wr_i | input | 1 | Write strobe for skip mode |
| skip_wdata_i | input | 1 | Value written to skip mode |
| rd_i | input | 1 | Receive register read strobe |
| irq_en_i | input | 1 | Interrupt enable |
| rx_data_o | output | 8 | Receive register |
| rx_full_o | output | 1 | Receive register holds unread byte |
| irq_o | output | 1 | Receive interrupt request |
| flag_o | output | 1 | Flag bit of last loaded character |
| ferr_o | output | 1 | Framing error |
| ovr_o | output | 1 | Overrun |
| skip_o | output | 1 | Current skip mode state |

## Verification
On every cycle, the assertions check these cycle-level rules:
- a skipped character never disturbs the register or the full flag;
- an address character disarms skip mode;
- an overrun keeps the stored byte;
- a read clears the full flag;
- the interrupt never rises without the full flag;
- a false start bit returns the sampler to idle.

Only the bench's scenarios can show the following:
- the byte assembled from the line matches the byte sent, for all 256 values and both flag values;
- characters are received correctly at a slower sample rate;
- a full address-then-payload message works from end to end;
- framing errors with the line recovering afterwards.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_FLAG,
    ST_STOP,
    ST_MARK
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              flag;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/mp_uart_sync.sv
module mp_uart_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mp_uart_sampler.sv
module mp_uart_sampler
  import mp_uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     rxd,
  input  logic     tick,
  output logic     done_o,
  output rx_char_t char_o
);
  localparam int unsigned CW = (OVS > 2) ? $clog2(OVS) : 1;
  localparam int unsigned BW = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              flag_q;
  logic              done_q;
  rx_char_t          char_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (state_q)
          ST_IDLE: begin
            if (!rxd) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              idx_q <= '0;
              state_q <= rxd ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              shift_q <= {rxd, shift_q[DATA_W-1:1]};
              if (idx_q == LAST_BIT) state_q <= ST_FLAG;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_FLAG: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              flag_q  <= rxd;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == FULL_M1) begin
              cnt_q       <= '0;
              done_q      <= 1'b1;
              char_q.data <= shift_q;
              char_q.flag <= flag_q;
              char_q.ferr <= ~rxd;
              state_q     <= rxd ? ST_IDLE : ST_MARK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_MARK: begin
            if (rxd) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign char_o = char_q;

  AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && tick && cnt_q == HALF_M1 && rxd) |=> state_q == ST_IDLE); // R8
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(state_q == ST_STOP)); // R1
  AST_MARK_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_MARK && !rxd) |=> state_q == ST_MARK); // R9
endmodule

// File: rtl/mp_uart_regs.sv
module mp_uart_regs
  import mp_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_char_t          char_i,
  input  logic              wr,
  input  logic              wdata,
  input  logic              rd,
  input  logic              irq_en,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o,
  output logic              flag_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              skip_o
);
  logic [DATA_W-1:0] data_q;
  logic full_q, irq_q, flag_q, ferr_q, ovr_q, skip_q;
  logic accept, full_kept, full_d;

  always_comb begin
    accept    = done & (~skip_q | char_i.flag);
    full_kept = full_q & ~rd;
    full_d    = accept | full_kept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      full_q <= full_d;
      irq_q  <= full_d & irq_en;
      if (rd) begin
        ovr_q  <= 1'b0;
        ferr_q <= 1'b0;
      end
      if (accept) begin
        if (full_kept) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= char_i.data;
          flag_q <= char_i.flag;
        end
        if (char_i.ferr) ferr_q <= 1'b1;
      end
      if (wr)                              skip_q <= wdata;
      else if (done && skip_q && char_i.flag) skip_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;
  assign flag_o = flag_q;
  assign ferr_o = ferr_q;
  assign ovr_o  = ovr_q;
  assign skip_o = skip_q;

  AST_SKIP_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (done && skip_q && !char_i.flag) |=> $stable(data_o)); // R3
  AST_SKIP_NO_FULL: assert property (@(posedge clk) disable iff (rst)
    (done && skip_q && !char_i.flag && !full_q) |=> !full_o); // R3
  AST_ADDR_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (done && skip_q && char_i.flag && !wr) |=> !skip_o); // R4
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (done && (!skip_q || char_i.flag) && full_q && !rd) |=> (ovr_o && $stable(data_o))); // R10
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd && !done) |=> !full_o); // R6
  AST_IRQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> full_o); // R11
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd_i,
  input  logic              sample_en_i,
  input  logic              skip_wr_i,
  input  logic              skip_wdata_i,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              irq_o,
  output logic              flag_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              skip_o
);
  logic     rxd_s;
  logic     done;
  rx_char_t rx_char;

  mp_uart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd_i),
    .dout (rxd_s)
  );

  mp_uart_sampler #(.OVS(OVS)) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .rxd    (rxd_s),
    .tick   (sample_en_i),
    .done_o (done),
    .char_o (rx_char)
  );

  mp_uart_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .char_i (rx_char),
    .wr     (skip_wr_i),
    .wdata  (skip_wdata_i),
    .rd     (rd_i),
    .irq_en (irq_en_i),
    .data_o (rx_data_o),
    .full_o (rx_full_o),
    .irq_o  (irq_o),
    .flag_o (flag_o),
    .ferr_o (ferr_o),
    .ovr_o  (ovr_o),
    .skip_o (skip_o)
  );
endmodule

// File: tb/mp_uart_rx_tb.sv
module mp_uart_rx_tb;
  localparam int OVS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic sample_en;
  logic skip_wr = 1'b0, skip_wdata = 1'b0, rd = 1'b0, irq_en = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, irq, flag, ferr, ovr, skip;

  int div = 1;
  int div_cnt = 0;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] exp_data;

  always #4 clk = ~clk;

  always_ff @(posedge clk) div_cnt <= (div_cnt >= div - 1) ? 0 : div_cnt + 1;
  assign sample_en = (div_cnt == div - 1);

  mp_uart_rx #(.OVS(OVS), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .rxd_i(rxd), .sample_en_i(sample_en),
    .skip_wr_i(skip_wr), .skip_wdata_i(skip_wdata), .rd_i(rd),
    .irq_en_i(irq_en), .rx_data_o(rx_data), .rx_full_o(rx_full),
    .irq_o(irq), .flag_o(flag), .ferr_o(ferr), .ovr_o(ovr), .skip_o(skip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic fl, input logic stopv);
    logic [10:0] bits;
    bits = {stopv, fl, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      repeat (OVS * div) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (OVS * div * 2) @(negedge clk);
  endtask

  task automatic do_read();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic write_skip(input logic v);
    skip_wr = 1'b1;
    skip_wdata = v;
    @(negedge clk);
    skip_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset data", {24'd0, rx_data}, 32'd0);
    chk("R1 reset full", {31'd0, rx_full}, 32'd0);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    chk("R7 reset skip", {31'd0, skip}, 32'd0);

    // R1 R2 R5 R11: every byte value, skip disarmed, flag alternating
    for (int b = 0; b < 256; b++) begin
      logic fl;
      fl = b[0] ^ b[7];
      irq_en = b[1];
      send(8'(b), fl, 1'b1);
      chk("R1 byte", {24'd0, rx_data}, 32'(b));
      chk("R5 full", {31'd0, rx_full}, 32'd1);
      chk("R2 flag", {31'd0, flag}, {31'd0, fl});
      chk("R11 irq", {31'd0, irq}, {31'd0, irq_en});
      do_read();
      chk("R6 full cleared", {31'd0, rx_full}, 32'd0);
      chk("R11 irq drops", {31'd0, irq}, 32'd0);
    end
    exp_data = 8'hFF;

    // R1 at half sample rate
    div = 2;
    foreach (exp_data[i]) begin end
    send(8'hA5, 1'b0, 1'b1);
    chk("R1 slow byte", {24'd0, rx_data}, 32'hA5);
    do_read();
    send(8'h3C, 1'b1, 1'b1);
    chk("R1 slow byte2", {24'd0, rx_data}, 32'h3C);
    chk("R2 slow flag", {31'd0, flag}, 32'd1);
    do_read();
    div = 1;
    exp_data = 8'h3C;

    // R7 R3 R4 skip mode
    irq_en = 1'b1;
    write_skip(1'b1);
    chk("R7 skip armed", {31'd0, skip}, 32'd1);
    for (int k = 0; k < 4; k++) begin
      send(8'(8'h11 * (k + 1)), 1'b0, 1'b1);
      chk("R3 data kept", {24'd0, rx_data}, {24'd0, exp_data});
      chk("R3 no full", {31'd0, rx_full}, 32'd0);
      chk("R3 no irq", {31'd0, irq}, 32'd0);
      chk("R3 still armed", {31'd0, skip}, 32'd1);
    end
    send(8'h42, 1'b1, 1'b1);
    chk("R4 address loaded", {24'd0, rx_data}, 32'h42);
    chk("R4 full", {31'd0, rx_full}, 32'd1);
    chk("R4 irq", {31'd0, irq}, 32'd1);
    chk("R4 disarmed", {31'd0, skip}, 32'd0);
    chk("R2 address flag", {31'd0, flag}, 32'd1);
    do_read();
    send(8'h99, 1'b0, 1'b1);
    chk("R5 payload after address", {24'd0, rx_data}, 32'h99);
    chk("R2 payload flag", {31'd0, flag}, 32'd0);
    do_read();
    write_skip(1'b1);
    write_skip(1'b0);
    chk("R7 write zero", {31'd0, skip}, 32'd0);

    // R10 overrun
    send(8'h12, 1'b0, 1'b1);
    send(8'h34, 1'b1, 1'b1);
    chk("R10 data kept", {24'd0, rx_data}, 32'h12);
    chk("R10 flag kept", {31'd0, flag}, 32'd0);
    chk("R10 ovr set", {31'd0, ovr}, 32'd1);
    do_read();
    chk("R6 ovr cleared", {31'd0, ovr}, 32'd0);

    // R9 framing error
    send(8'h5A, 1'b0, 1'b0);
    chk("R9 ferr set", {31'd0, ferr}, 32'd1);
    chk("R9 data", {24'd0, rx_data}, 32'h5A);
    do_read();
    chk("R6 ferr cleared", {31'd0, ferr}, 32'd0);
    send(8'hC3, 1'b0, 1'b1);
    chk("R9 recovers", {24'd0, rx_data}, 32'hC3);
    chk("R9 no ferr", {31'd0, ferr}, 32'd0);
    do_read();

    // R8 glitch
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (OVS * 14) @(negedge clk);
    chk("R8 no char", {31'd0, rx_full}, 32'd0);
    chk("R8 data kept", {24'd0, rx_data}, 32'hC3);

    // R11 enable gating
    irq_en = 1'b0;
    send(8'h77, 1'b0, 1'b1);
    chk("R11 gated off", {31'd0, irq}, 32'd0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R11 enabled", {31'd0, irq}, 32'd1);
    do_read();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule